// File: doc/BRIEF.md
# Low-Power Clock Enable Controller

This block sits between the clock sources of a small system and its three clocked domains: the CPU, the general peripherals and an always-on timer. It picks one of three sources, a PLL clock, a main oscillator clock or a slow sub-oscillator clock. Each source arrives as a one-cycle tick on a fast reference clock. The block divides the chosen source into a system tick and turns that tick into per-domain clock-enable pulses.

A small control register selects what happens next. The CPU can request sleep (CPU held, peripherals running), timer-only operation (only the always-on timer ticking) or stop (every domain held and the active oscillator asked to power down). It can also thin out CPU pulses in a fixed window to save power while the CPU keeps running. When the sub clock is the source, the always-on timer is a watch timer and gets its own enable. Otherwise it is a time-base timer.

An interrupt request brings the block back to run. After stop, a programmable settling count must expire before clocks are handed out again. Every mode change is aligned to a system tick, so no enable output ever delivers part of a pulse.

Top module: `lpm_clkctl`

## Requirements
- R1: The system tick is one per selected source tick for the PLL (`src_sel` 0 or 3), one per two oscillator ticks (`src_sel` 1) and one per four sub-clock ticks (`src_sel` 2).
- R2: In run mode (`lp_mode` 0), every system tick gives one pulse on `cpu_en`, one on `per_en` and one on the active timer enable.
- R3: In sleep mode (`lp_mode` 1), `cpu_en` stays low while `per_en` and the active timer enable pulse on every system tick.
- R4: In timer-only mode (`lp_mode` 2), only the active timer enable pulses, and `cpu_en` and `per_en` stay low.
- R5: The timer pulses appear on `wtm_en` when the sub clock is selected and on `tmr_en` otherwise, never on both.
- R6: In stop mode (`lp_mode` 3), no enable pulses. `osc_stop_req` is high if a main or PLL source was active, or `sub_stop_req` is high if the sub clock was active.
- R7: With control bit 4 at 0, the CPU pulses are thinned in a fixed window of 8 system ticks. Out of every 8 ticks, 2n+1 CPU pulses are dropped, where n is control bits [2:1].
- R8: The control register resets to 0x18. Bit 7 requests stop, bit 6 requests sleep and bit 5 requests timer-only. These three bits are write-only and read back as 0. `ctl_rd` returns {000, bits [4:0]}.
- R9: When several requests are written together, stop wins over timer-only, and timer-only wins over sleep.
- R10: In sleep or timer-only mode, an `irq` that is high at a system tick returns the block to run.
- R11: In stop mode, a high `irq` moves the block to settling (`lp_mode` 4) at the next clock edge and drops both stop requests. The block returns to run `stab_len`+1 clock edges later.
- R12: A request takes effect at the next system tick. The enables produced on that tick still follow the old mode.
- R13: Register writes are ignored while the block is not in run mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast reference clock |
| rst_n | input | 1 | Active-low synchronous reset |
| src_sel | input | 2 | Source select: 0/3 PLL, 1 main oscillator, 2 sub clock |
| pll_tick | input | 1 | PLL clock edge marker |
| osc_tick | input | 1 | Main oscillator edge marker |
| sub_tick | input | 1 | Sub-oscillator edge marker |
| wr_en | input | 1 | Control register write strobe |
| wr_data | input | 8 | Control register write data |
| irq | input | 1 | Enabled interrupt request (wake-up) |
| stab_len | input | STAB_W | Oscillator settling count after stop |
| ctl_rd | output | 8 | Control register readback |
| lp_mode | output | 3 | Current mode: 0 run, 1 sleep, 2 timer-only, 3 stop, 4 settling |
| cpu_en | output | 1 | CPU clock enable pulse |
| per_en | output | 1 | Peripheral clock enable pulse |
| tmr_en | output | 1 | Time-base timer enable pulse |
| wtm_en | output | 1 | Watch timer enable pulse |
| osc_stop_req | output | 1 | Request to stop the main oscillator |
| sub_stop_req | output | 1 | Request to stop the sub oscillator |

## Verification
The main sweep covers all three sources crossed with run, sleep and timer-only. Run is further crossed with every thinning amount, with thinning both on and off. In each case the bench counts the pulses on every enable over 16 system ticks. This separates division-ratio errors from gating errors and from watch/time-base swaps. Stop is entered from each source, which shows whether the correct oscillator is asked to stop. Separate single-tick runs check that a request lands on a tick edge and that a wake from stop waits out the settling count exactly. Combined-request writes and writes made while asleep show the request priority and show that non-run writes are ignored.

// File: rtl/lpm_pkg.sv
package lpm_pkg;
    typedef enum logic [2:0] {
        M_RUN   = 3'd0,
        M_SLEEP = 3'd1,
        M_TMR   = 3'd2,
        M_STOP  = 3'd3,
        M_STAB  = 3'd4
    } lpm_mode_e;

    localparam logic [1:0] SRC_OSC = 2'd1;
    localparam logic [1:0] SRC_SUB = 2'd2;

    localparam logic [4:0] CFG_RESET = 5'b11000;
endpackage

// File: rtl/lpm_div.sv
module lpm_div #(
    parameter int OSC_DIV = 2,
    parameter int SUB_DIV = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] src_sel,
    input  logic       pll_tick,
    input  logic       osc_tick,
    input  logic       sub_tick,
    output logic       sys_tick
);
    import lpm_pkg::*;

    localparam int MAXDIV = (OSC_DIV > SUB_DIV) ? OSC_DIV : SUB_DIV;
    localparam int CW     = $clog2(MAXDIV) + 1;

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic          tick;
    } div_st_t;

    div_st_t q, d;
    logic          raw;
    logic [CW-1:0] lim;
    logic          wrap;

    always_comb begin
        case (src_sel)
            SRC_OSC: begin raw = osc_tick; lim = CW'(OSC_DIV); end
            SRC_SUB: begin raw = sub_tick; lim = CW'(SUB_DIV); end
            default: begin raw = pll_tick; lim = CW'(1);       end
        endcase
        wrap   = (q.cnt == lim - CW'(1));
        d      = q;
        d.tick = raw && wrap;
        if (raw) begin
            d.cnt = wrap ? '0 : q.cnt + CW'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign sys_tick = q.tick;
endmodule

// File: rtl/lpm_decim.sv
module lpm_decim #(
    parameter int PERIOD_W = 3
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       step,
    input  logic       thin_on,
    input  logic [1:0] amount,
    output logic       allow
);
    logic [PERIOD_W-1:0] phase_d, phase_q;
    logic [PERIOD_W:0]   thr;

    always_comb begin
        thr     = {{(PERIOD_W-2){1'b0}}, amount, 1'b1};
        allow   = !thin_on || ({1'b0, phase_q} >= thr);
        phase_d = step ? phase_q + PERIOD_W'(1) : phase_q;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) phase_q <= '0;
        else        phase_q <= phase_d;
    end
endmodule

// File: rtl/lpm_clkctl.sv
module lpm_clkctl #(
    parameter int OSC_DIV  = 2,
    parameter int SUB_DIV  = 4,
    parameter int PERIOD_W = 3,
    parameter int STAB_W   = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        src_sel,
    input  logic              pll_tick,
    input  logic              osc_tick,
    input  logic              sub_tick,
    input  logic              wr_en,
    input  logic [7:0]        wr_data,
    input  logic              irq,
    input  logic [STAB_W-1:0] stab_len,
    output logic [7:0]        ctl_rd,
    output logic [2:0]        lp_mode,
    output logic              cpu_en,
    output logic              per_en,
    output logic              tmr_en,
    output logic              wtm_en,
    output logic              osc_stop_req,
    output logic              sub_stop_req
);
    import lpm_pkg::*;

    typedef struct packed {
        lpm_mode_e         mode;
        logic              p_stop;
        logic              p_tmr;
        logic              p_sleep;
        logic [4:0]        cfg;
        logic [STAB_W-1:0] stab_cnt;
        logic              osc_stop;
        logic              sub_stop;
        logic              cpu;
        logic              per;
        logic              tbt;
        logic              wtm;
    } st_t;

    st_t  q, d;
    logic sys_tick;
    logic allow;
    logic on_sub;
    logic w_ok;
    logic e_stop, e_tmr, e_sleep;

    lpm_div #(.OSC_DIV(OSC_DIV), .SUB_DIV(SUB_DIV)) u_div (
        .clk      (clk),
        .rst_n    (rst_n),
        .src_sel  (src_sel),
        .pll_tick (pll_tick),
        .osc_tick (osc_tick),
        .sub_tick (sub_tick),
        .sys_tick (sys_tick)
    );

    lpm_decim #(.PERIOD_W(PERIOD_W)) u_decim (
        .clk     (clk),
        .rst_n   (rst_n),
        .step    (sys_tick && (q.mode == M_RUN)),
        .thin_on (!q.cfg[4]),
        .amount  (q.cfg[2:1]),
        .allow   (allow)
    );

    always_comb begin
        on_sub  = (src_sel == SRC_SUB);
        w_ok    = wr_en && (q.mode == M_RUN);
        e_stop  = q.p_stop  || (w_ok && wr_data[7]);
        e_tmr   = q.p_tmr   || (w_ok && wr_data[5]);
        e_sleep = q.p_sleep || (w_ok && wr_data[6]);

        d         = q;
        d.cpu     = 1'b0;
        d.per     = 1'b0;
        d.tbt     = 1'b0;
        d.wtm     = 1'b0;
        d.p_stop  = e_stop;
        d.p_tmr   = e_tmr;
        d.p_sleep = e_sleep;
        if (w_ok) d.cfg = wr_data[4:0];

        case (q.mode)
            M_RUN: begin
                if (sys_tick) begin
                    d.cpu = allow;
                    d.per = 1'b1;
                    d.tbt = !on_sub;
                    d.wtm = on_sub;
                    if (e_stop) begin
                        d.mode     = M_STOP;
                        d.osc_stop = !on_sub;
                        d.sub_stop = on_sub;
                    end else if (e_tmr) begin
                        d.mode = M_TMR;
                    end else if (e_sleep) begin
                        d.mode = M_SLEEP;
                    end
                    d.p_stop  = 1'b0;
                    d.p_tmr   = 1'b0;
                    d.p_sleep = 1'b0;
                end
            end
            M_SLEEP, M_TMR: begin
                if (sys_tick) begin
                    d.per = (q.mode == M_SLEEP);
                    d.tbt = !on_sub;
                    d.wtm = on_sub;
                    if (irq) d.mode = M_RUN;
                end
            end
            M_STOP: begin
                if (irq) begin
                    d.mode     = M_STAB;
                    d.stab_cnt = stab_len;
                    d.osc_stop = 1'b0;
                    d.sub_stop = 1'b0;
                end
            end
            default: begin
                if (q.stab_cnt == '0) d.mode = M_RUN;
                else                  d.stab_cnt = q.stab_cnt - STAB_W'(1);
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q      <= '0;
            q.mode <= M_RUN;
            q.cfg  <= CFG_RESET;
        end else begin
            q <= d;
        end
    end

    assign ctl_rd       = {3'b000, q.cfg};
    assign lp_mode      = q.mode;
    assign cpu_en       = q.cpu;
    assign per_en       = q.per;
    assign tmr_en       = q.tbt;
    assign wtm_en       = q.wtm;
    assign osc_stop_req = q.osc_stop;
    assign sub_stop_req = q.sub_stop;
endmodule

// File: rtl/lpm_clkctl_chk.sv
module lpm_clkctl_chk (
    input logic       clk,
    input logic       rst_n,
    input logic [2:0] lp_mode,
    input logic       cpu_en,
    input logic       per_en,
    input logic       tmr_en,
    input logic       wtm_en,
    input logic       osc_stop_req,
    input logic       sub_stop_req
);
    AST_CPU_ONLY_FROM_RUN: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_en |-> $past(lp_mode == 3'd0));                              // R12
    AST_PER_NOT_IN_TIMER: assert property (@(posedge clk) disable iff (!rst_n)
        per_en |-> ($past(lp_mode) == 3'd0 || $past(lp_mode) == 3'd1));  // R4
    AST_STOP_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        (lp_mode == 3'd3) |=> !(cpu_en || per_en || tmr_en || wtm_en));  // R6
    AST_ONE_TIMER: assert property (@(posedge clk) disable iff (!rst_n)
        !(tmr_en && wtm_en));                                             // R5
    AST_ONE_STOP_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({osc_stop_req, sub_stop_req}));                          // R6
    AST_REQ_ONLY_IN_STOP: assert property (@(posedge clk) disable iff (!rst_n)
        (osc_stop_req || sub_stop_req) |-> (lp_mode == 3'd3));            // R11
endmodule

bind lpm_clkctl lpm_clkctl_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .lp_mode      (lp_mode),
    .cpu_en       (cpu_en),
    .per_en       (per_en),
    .tmr_en       (tmr_en),
    .wtm_en       (wtm_en),
    .osc_stop_req (osc_stop_req),
    .sub_stop_req (sub_stop_req)
);

// File: tb/sim_lpm_clkctl.sv
module sim_lpm_clkctl;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] src_sel = 2'd0;
    logic       rawt = 1'b0;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = 8'd0;
    logic       irq = 1'b0;
    logic [7:0] stab_len = 8'd5;
    logic [7:0] ctl_rd;
    logic [2:0] lp_mode;
    logic       cpu_en, per_en, tmr_en, wtm_en, osc_stop_req, sub_stop_req;

    int n_chk = 0, n_fail = 0;
    int c_cpu = 0, c_per = 0, c_tmr = 0, c_wtm = 0;

    always #5 clk = ~clk;

    lpm_clkctl u0 (
        .clk(clk), .rst_n(rst_n), .src_sel(src_sel),
        .pll_tick(rawt), .osc_tick(rawt), .sub_tick(rawt),
        .wr_en(wr_en), .wr_data(wr_data), .irq(irq), .stab_len(stab_len),
        .ctl_rd(ctl_rd), .lp_mode(lp_mode), .cpu_en(cpu_en), .per_en(per_en),
        .tmr_en(tmr_en), .wtm_en(wtm_en),
        .osc_stop_req(osc_stop_req), .sub_stop_req(sub_stop_req)
    );

    always @(negedge clk) begin
        if (cpu_en) c_cpu++;
        if (per_en) c_per++;
        if (tmr_en) c_tmr++;
        if (wtm_en) c_wtm++;
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic ceq(input string tag, input int act, input int exp);
        chk(act == exp, tag, act, exp);
    endtask

    task automatic do_reset(input logic [1:0] s);
        @(negedge clk);
        rst_n = 1'b0; src_sel = s; irq = 1'b0; wr_en = 1'b0; rawt = 1'b0;
        @(negedge clk);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic pulse(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk) rawt = 1'b1;
            @(negedge clk) rawt = 1'b0;
        end
    endtask

    task automatic drain();
        repeat (3) @(negedge clk);
    endtask

    task automatic wr(input logic [7:0] v);
        @(negedge clk);
        wr_en = 1'b1; wr_data = v;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic clr();
        c_cpu = 0; c_per = 0; c_tmr = 0; c_wtm = 0;
    endtask

    function automatic int divof(input int s);
        return (s == 0) ? 1 : (s == 1) ? 2 : 4;
    endfunction

    initial begin
        #2_000_000;
        n_chk++; n_fail++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        // R8 reset value and write-only request bits
        do_reset(2'd0);
        ceq("R8 reset ctl_rd", ctl_rd, 8'h18);
        ceq("R8 reset mode", lp_mode, 0);
        wr(8'h46);
        ceq("R8 request bits read 0", ctl_rd, 8'h06);

        // R1..R5, R7: sweep source x mode x thinning
        for (int s = 0; s < 3; s++) begin
            for (int m = 0; m < 3; m++) begin
                for (int io = 0; io < 2; io++) begin
                    for (int n = 0; n < 4; n++) begin
                        int dv, ecpu, eper, etm;
                        logic [7:0] v;
                        dv = divof(s);
                        v  = {1'b0, (m == 1), (m == 2), io[0], 1'b1, n[1:0], 1'b0};
                        do_reset(s[1:0]);
                        wr(v);
                        pulse(dv);
                        drain();
                        ceq($sformatf("R12 mode s%0d m%0d", s, m), lp_mode, m);
                        clr();
                        pulse(16 * dv);
                        drain();
                        ecpu = (m != 0) ? 0 : (io == 1) ? 16 : 16 - 2 * (2 * n + 1);
                        eper = (m == 2) ? 0 : 16;
                        etm  = 16;
                        ceq($sformatf("R2 R3 R4 R7 cpu s%0d m%0d io%0d n%0d", s, m, io, n), c_cpu, ecpu);
                        ceq($sformatf("R1 R3 R4 per s%0d m%0d", s, m), c_per, eper);
                        ceq($sformatf("R1 R5 tmr s%0d m%0d", s, m), c_tmr, (s == 2) ? 0 : etm);
                        ceq($sformatf("R5 wtm s%0d m%0d", s, m), c_wtm, (s == 2) ? etm : 0);
                    end
                end
            end
        end

        // R6, R11: stop and wake from each source
        for (int s = 0; s < 3; s++) begin
            int dv;
            dv = divof(s);
            do_reset(s[1:0]);
            wr(8'h98);
            pulse(dv);
            drain();
            ceq("R6 stop mode", lp_mode, 3);
            ceq("R6 osc stop req", osc_stop_req, (s != 2));
            ceq("R6 sub stop req", sub_stop_req, (s == 2));
            clr();
            pulse(16 * dv);
            drain();
            ceq("R6 no pulses in stop", c_cpu + c_per + c_tmr + c_wtm, 0);
            @(negedge clk) irq = 1'b1;
            @(posedge clk);
            @(negedge clk) irq = 1'b0;
            ceq("R11 settling mode", lp_mode, 4);
            ceq("R11 stop req dropped", osc_stop_req + sub_stop_req, 0);
            repeat (5) @(posedge clk);
            @(negedge clk);
            ceq("R11 still settling", lp_mode, 4);
            @(posedge clk);
            @(negedge clk);
            ceq("R11 back to run", lp_mode, 0);
            clr();
            pulse(16 * dv);
            drain();
            ceq("R11 cpu after wake", c_cpu, 16);
        end

        // R9 priority
        do_reset(2'd0);
        wr(8'hD8);
        pulse(1); drain();
        ceq("R9 stop over sleep", lp_mode, 3);
        do_reset(2'd0);
        wr(8'h78);
        pulse(1); drain();
        ceq("R9 timer over sleep", lp_mode, 2);
        do_reset(2'd0);
        wr(8'hF8);
        pulse(1); drain();
        ceq("R9 stop over all", lp_mode, 3);

        // R12 request lands on tick; that tick still uses old mode
        do_reset(2'd0);
        wr(8'h58);
        drain();
        ceq("R12 no change without tick", lp_mode, 0);
        clr();
        pulse(1); drain();
        ceq("R12 tick keeps old cpu pulse", c_cpu, 1);
        ceq("R12 sleep after tick", lp_mode, 1);
        clr();
        pulse(1); drain();
        ceq("R12 no cpu after sleep", c_cpu, 0);

        // R10, R13: wake from sleep; write while asleep ignored
        do_reset(2'd1);
        wr(8'h58);
        pulse(2); drain();
        ceq("R10 in sleep", lp_mode, 1);
        wr(8'h87);
        ceq("R13 cfg unchanged", ctl_rd, 8'h18);
        pulse(4); drain();
        ceq("R10 stays asleep without irq", lp_mode, 1);
        irq = 1'b1;
        pulse(2); drain();
        irq = 1'b0;
        ceq("R10 woke to run", lp_mode, 0);
        pulse(4); drain();
        ceq("R13 stop request not held", lp_mode, 0);

        // R10 wake from timer-only with sub clock
        do_reset(2'd2);
        wr(8'h38);
        pulse(4); drain();
        ceq("R10 in timer-only", lp_mode, 2);
        irq = 1'b1;
        pulse(4); drain();
        irq = 1'b0;
        ceq("R10 timer-only woke", lp_mode, 0);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule